// File: doc/BRIEF.md
# CR8 Task-Priority Shadow Access Controller

This block decides, cycle by cycle, how a guest's reads and writes of the CR8 task-priority register are handled while it runs under a virtual machine monitor. Depending on three execution-control bits it does one of three things. It serves the access from a 4-bit priority shadow kept in a virtual interrupt-controller page. It hands the access to the native priority register. Or it raises a virtual-machine exit with a cause code.

A shadow write is mirrored into the virtual page as one byte write. After such a write completes, the new value is compared with the low nibble of a 32-bit threshold register. A value that falls below the threshold produces an exit one cycle after the page write. Requests are single-cycle strobes. All results appear on registered outputs one clock after the request, except the below-threshold exit, which comes two clocks after it.

Top module: `cr8_shadow_ctrl`

## Requirements
- R1: After synchronous reset every output strobe is low and the held shadow value is 0.
- R2: A read with use-shadow = 1 and store-exiting = 0 gives `rd_valid_o` = 1 one cycle later. `rd_data_o` carries the shadow value and no exit is raised.
- R3: A read with store-exiting = 1 raises `exit_o` for one cycle, one cycle later, with cause 0. This happens whatever use-shadow is, and no read data is returned.
- R4: A write with load-exiting = 1 raises `exit_o` one cycle later with cause 1, whatever use-shadow is. There is no page write and no native write, and the shadow keeps its old value.
- R5: A write with use-shadow = 1 and load-exiting = 0 updates the shadow. One cycle later it drives `page_we_o` with address 0x080, data bits 7:4 equal to the written value, and bits 3:0 zero.
- R6: After a shadow write, the written value is compared unsigned with `threshold_i[3:0]`, and threshold bits 31:4 play no part. If it is strictly below, `exit_o` pulses with cause 2 two cycles after the request. An equal value raises no exit.
- R7: With use-shadow = 0 and the relevant exiting bit 0, the access goes to the native path with no exit. A write drives `native_we_o` and `native_wdata_o` one cycle later. A read returns `native_rdata_i` as sampled at the request edge.
- R8: When a read and a write arrive in the same cycle, the write is handled first. A served read returns the newly written value. If the write leads to an exit (cause 1 or 2), the paired read is dropped with no data and no store exit.
- R9: Any request presented in the cycle right after a below-threshold shadow write is ignored, so two exits never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| use_shadow_i | input | 1 | Serve CR8 accesses from the priority shadow |
| store_exit_en_i | input | 1 | CR8 reads cause an exit |
| load_exit_en_i | input | 1 | CR8 writes cause an exit |
| threshold_i | input | 32 | Threshold register; only bits 3:0 compared |
| rd_req_i | input | 1 | Single-cycle CR8 read request |
| wr_req_i | input | 1 | Single-cycle CR8 write request |
| wr_data_i | input | 4 | Value written to CR8 |
| native_rdata_i | input | 4 | Current native priority register value |
| rd_valid_o | output | 1 | Read data valid strobe |
| rd_data_o | output | 4 | Read result |
| page_we_o | output | 1 | Byte write strobe into the virtual page |
| page_addr_o | output | 12 | Byte offset within the virtual page |
| page_wdata_o | output | 8 | Byte written into the virtual page |
| native_we_o | output | 1 | Write strobe to the native priority register |
| native_wdata_o | output | 4 | Value for the native priority register |
| exit_o | output | 1 | One-cycle exit pulse |
| exit_cause_o | output | 2 | Exit cause: 0 store, 1 load, 2 below threshold |

## Verification
The assertions watch the following on every cycle:
- the routing for unpaired accesses: store exits, load exits with no page or native write, shadow reads, and native writes with their data;
- the page byte layout;
- the below-threshold exit following any page write whose value is under the threshold sampled with it;
- the silence of all strobes after a request that arrives while a threshold exit is pending.

Only the bench's scenarios can show that the shadow really keeps its value across a load exit. The same goes for the upper threshold bits being ignored, the equal-value boundary, and the precedence of a write over a read in the same cycle, since these need values carried across several separate accesses.

// File: rtl/cr8_shadow_pkg.sv
package cr8_shadow_pkg;

    // Architectural width of the task-priority value and of one page byte
    localparam int PRIO_W = 4;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        CAUSE_STORE = 2'd0,
        CAUSE_LOAD  = 2'd1,
        CAUSE_BELOW = 2'd2
    } exit_cause_e;

    // Per-cycle action set chosen by the route decoder
    typedef struct packed {
        logic wr_shadow;
        logic wr_native;
        logic wr_load_exit;
        logic wr_below;
        logic rd_shadow;
        logic rd_native;
        logic rd_store_exit;
    } cr8_act_t;

    function automatic logic prio_below(input logic [PRIO_W-1:0] val,
                                        input logic [PRIO_W-1:0] limit);
        return val < limit;
    endfunction

    function automatic logic [BYTE_W-1:0] shadow_byte(input logic [PRIO_W-1:0] val);
        return {val, {(BYTE_W-PRIO_W){1'b0}}};
    endfunction

endpackage

// File: rtl/cr8_route_dec.sv
module cr8_route_dec
    import cr8_shadow_pkg::*;
(
    input  logic              use_shadow,
    input  logic              store_exit_en,
    input  logic              load_exit_en,
    input  logic [PRIO_W-1:0] thr_lo,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [PRIO_W-1:0] wr_data,
    input  logic              busy,
    output cr8_act_t          act
);

    logic wr_go;
    logic rd_go;
    logic wr_exits;

    assign wr_go = wr_req && !busy;
    assign rd_go = rd_req && !busy;

    always_comb begin
        act = '0;
        // The write is resolved first; exiting bits outrank the shadow bit
        if (wr_go) begin
            if (load_exit_en) begin
                act.wr_load_exit = 1'b1;
            end else if (use_shadow) begin
                act.wr_shadow = 1'b1;
                act.wr_below  = prio_below(wr_data, thr_lo);
            end else begin
                act.wr_native = 1'b1;
            end
        end
        wr_exits = act.wr_load_exit || act.wr_below;
        // A read paired with an exiting write is dropped
        if (rd_go && !wr_exits) begin
            if (store_exit_en) begin
                act.rd_store_exit = 1'b1;
            end else if (use_shadow) begin
                act.rd_shadow = 1'b1;
            end else begin
                act.rd_native = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cr8_shadow_store.sv
module cr8_shadow_store
    import cr8_shadow_pkg::*;
#(
    parameter int                 PAGE_AW    = 12,
    parameter logic [PAGE_AW-1:0] SHADOW_OFS = 12'h080
) (
    input  logic               clk,
    input  logic               rst,
    input  cr8_act_t           act,
    input  logic [PRIO_W-1:0]  wr_data,
    output logic [PRIO_W-1:0]  shadow_q,
    output logic               page_we,
    output logic [PAGE_AW-1:0] page_addr,
    output logic [BYTE_W-1:0]  page_wdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q   <= '0;
            page_we    <= 1'b0;
            page_addr  <= '0;
            page_wdata <= '0;
        end else begin
            page_we <= act.wr_shadow;
            if (act.wr_shadow) begin
                shadow_q   <= wr_data;
                page_addr  <= SHADOW_OFS;
                page_wdata <= shadow_byte(wr_data);
            end
        end
    end

endmodule

// File: rtl/cr8_exit_seq.sv
module cr8_exit_seq
    import cr8_shadow_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  cr8_act_t    act,
    output logic        exit_q,
    output exit_cause_e cause_q,
    output logic        thr_pend_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            exit_q     <= 1'b0;
            cause_q    <= CAUSE_STORE;
            thr_pend_q <= 1'b0;
        end else begin
            // Below-threshold exit is held one cycle so it follows the page write
            thr_pend_q <= act.wr_below;
            exit_q     <= thr_pend_q || act.wr_load_exit || act.rd_store_exit;
            if (thr_pend_q) begin
                cause_q <= CAUSE_BELOW;
            end else if (act.wr_load_exit) begin
                cause_q <= CAUSE_LOAD;
            end else if (act.rd_store_exit) begin
                cause_q <= CAUSE_STORE;
            end
        end
    end

endmodule

// File: rtl/cr8_shadow_ctrl.sv
module cr8_shadow_ctrl
    import cr8_shadow_pkg::*;
#(
    parameter int                 THR_W      = 32,
    parameter int                 PAGE_AW    = 12,
    parameter logic [PAGE_AW-1:0] SHADOW_OFS = 12'h080
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               use_shadow_i,
    input  logic               store_exit_en_i,
    input  logic               load_exit_en_i,
    input  logic [THR_W-1:0]   threshold_i,
    input  logic               rd_req_i,
    input  logic               wr_req_i,
    input  logic [PRIO_W-1:0]  wr_data_i,
    input  logic [PRIO_W-1:0]  native_rdata_i,
    output logic               rd_valid_o,
    output logic [PRIO_W-1:0]  rd_data_o,
    output logic               page_we_o,
    output logic [PAGE_AW-1:0] page_addr_o,
    output logic [BYTE_W-1:0]  page_wdata_o,
    output logic               native_we_o,
    output logic [PRIO_W-1:0]  native_wdata_o,
    output logic               exit_o,
    output logic [1:0]         exit_cause_o
);

    logic [PRIO_W-1:0] thr_lo;
    logic              unused_thr_hi;
    cr8_act_t          act;
    logic              thr_pend_q;
    logic [PRIO_W-1:0] shadow_q;
    exit_cause_e       cause_q;

    assign thr_lo        = threshold_i[PRIO_W-1:0];
    assign unused_thr_hi = ^threshold_i[THR_W-1:PRIO_W];

    cr8_route_dec u_dec (
        .use_shadow    (use_shadow_i),
        .store_exit_en (store_exit_en_i),
        .load_exit_en  (load_exit_en_i),
        .thr_lo        (thr_lo),
        .rd_req        (rd_req_i),
        .wr_req        (wr_req_i),
        .wr_data       (wr_data_i),
        .busy          (thr_pend_q),
        .act           (act)
    );

    cr8_shadow_store #(
        .PAGE_AW    (PAGE_AW),
        .SHADOW_OFS (SHADOW_OFS)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .wr_data    (wr_data_i),
        .shadow_q   (shadow_q),
        .page_we    (page_we_o),
        .page_addr  (page_addr_o),
        .page_wdata (page_wdata_o)
    );

    cr8_exit_seq u_exit (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .exit_q     (exit_o),
        .cause_q    (cause_q),
        .thr_pend_q (thr_pend_q)
    );

    assign exit_cause_o = cause_q;

    // Read return and native register path; same-cycle write is seen first
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o     <= 1'b0;
            rd_data_o      <= '0;
            native_we_o    <= 1'b0;
            native_wdata_o <= '0;
        end else begin
            rd_valid_o  <= act.rd_shadow || act.rd_native;
            native_we_o <= act.wr_native;
            if (act.wr_native) begin
                native_wdata_o <= wr_data_i;
            end
            if (act.rd_shadow) begin
                rd_data_o <= act.wr_shadow ? wr_data_i : shadow_q;
            end else if (act.rd_native) begin
                rd_data_o <= act.wr_native ? wr_data_i : native_rdata_i;
            end
        end
    end

endmodule

// File: rtl/cr8_shadow_ctrl_chk.sv
module cr8_shadow_ctrl_chk
    import cr8_shadow_pkg::*;
#(
    parameter int                 PAGE_AW    = 12,
    parameter logic [PAGE_AW-1:0] SHADOW_OFS = 12'h080
) (
    input logic               clk,
    input logic               rst,
    input logic               use_shadow_i,
    input logic               store_exit_en_i,
    input logic               load_exit_en_i,
    input logic [PRIO_W-1:0]  thr_lo,
    input logic               rd_req_i,
    input logic               wr_req_i,
    input logic [PRIO_W-1:0]  wr_data_i,
    input logic               thr_pend_q,
    input logic               rd_valid_o,
    input logic               page_we_o,
    input logic [PAGE_AW-1:0] page_addr_o,
    input logic [BYTE_W-1:0]  page_wdata_o,
    input logic               native_we_o,
    input logic [PRIO_W-1:0]  native_wdata_o,
    input logic               exit_o,
    input logic [1:0]         exit_cause_o
);

    p_shadow_read_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_req_i && use_shadow_i && !store_exit_en_i && !wr_req_i && !thr_pend_q)
        |=> (rd_valid_o && !exit_o));

    p_store_exit_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_req_i && store_exit_en_i && !wr_req_i && !thr_pend_q)
        |=> (exit_o && exit_cause_o == 2'd0 && !rd_valid_o));

    p_load_exit_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_req_i && load_exit_en_i && !thr_pend_q)
        |=> (exit_o && exit_cause_o == 2'd1 && !page_we_o && !native_we_o));

    p_page_layout_r5: assert property (@(posedge clk) disable iff (rst)
        page_we_o |-> (page_addr_o == SHADOW_OFS &&
                       page_wdata_o[BYTE_W-PRIO_W-1:0] == '0));

    p_below_exit_r6: assert property (@(posedge clk) disable iff (rst)
        (page_we_o && (page_wdata_o[BYTE_W-1 -: PRIO_W] < $past(thr_lo)))
        |=> (exit_o && exit_cause_o == 2'd2));

    p_native_write_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_req_i && !use_shadow_i && !load_exit_en_i && !thr_pend_q)
        |=> (native_we_o && native_wdata_o == $past(wr_data_i) && !page_we_o));

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        thr_pend_q |=> (!page_we_o && !native_we_o && !rd_valid_o));

    p_cause_legal_r6: assert property (@(posedge clk) disable iff (rst)
        exit_o |-> (exit_cause_o != 2'd3));

endmodule

bind cr8_shadow_ctrl cr8_shadow_ctrl_chk #(
    .PAGE_AW    (PAGE_AW),
    .SHADOW_OFS (SHADOW_OFS)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .use_shadow_i    (use_shadow_i),
    .store_exit_en_i (store_exit_en_i),
    .load_exit_en_i  (load_exit_en_i),
    .thr_lo          (thr_lo),
    .rd_req_i        (rd_req_i),
    .wr_req_i        (wr_req_i),
    .wr_data_i       (wr_data_i),
    .thr_pend_q      (thr_pend_q),
    .rd_valid_o      (rd_valid_o),
    .page_we_o       (page_we_o),
    .page_addr_o     (page_addr_o),
    .page_wdata_o    (page_wdata_o),
    .native_we_o     (native_we_o),
    .native_wdata_o  (native_wdata_o),
    .exit_o          (exit_o),
    .exit_cause_o    (exit_cause_o)
);

// File: tb/cr8_shadow_ctrl_bench.sv
module cr8_shadow_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        use_shadow_i, store_exit_en_i, load_exit_en_i;
    logic [31:0] threshold_i;
    logic        rd_req_i, wr_req_i;
    logic [3:0]  wr_data_i, native_rdata_i;
    logic        rd_valid_o;
    logic [3:0]  rd_data_o;
    logic        page_we_o;
    logic [11:0] page_addr_o;
    logic [7:0]  page_wdata_o;
    logic        native_we_o;
    logic [3:0]  native_wdata_o;
    logic        exit_o;
    logic [1:0]  exit_cause_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cr8_shadow_ctrl u_cr8_shadow_ctrl (
        .clk             (clk),
        .rst             (rst),
        .use_shadow_i    (use_shadow_i),
        .store_exit_en_i (store_exit_en_i),
        .load_exit_en_i  (load_exit_en_i),
        .threshold_i     (threshold_i),
        .rd_req_i        (rd_req_i),
        .wr_req_i        (wr_req_i),
        .wr_data_i       (wr_data_i),
        .native_rdata_i  (native_rdata_i),
        .rd_valid_o      (rd_valid_o),
        .rd_data_o       (rd_data_o),
        .page_we_o       (page_we_o),
        .page_addr_o     (page_addr_o),
        .page_wdata_o    (page_wdata_o),
        .native_we_o     (native_we_o),
        .native_wdata_o  (native_wdata_o),
        .exit_o          (exit_o),
        .exit_cause_o    (exit_cause_o)
    );

    typedef struct packed {
        logic        use_s; logic st; logic ld; logic [31:0] thr;
        logic        rd; logic wr; logic [3:0] wd; logic [3:0] nat;
        logic        rv; logic [3:0] rdat; logic pwe; logic [7:0] pdat;
        logic        nwe; logic [3:0] ndat; logic ex; logic [1:0] cs; logic ex2;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1,0,0,32'h5,        0,1,4'h9,4'h0, 0,4'h0,1,8'h90,0,4'h0,0,2'd0,0}, // R5
        '{1,0,0,32'h5,        1,0,4'h0,4'h0, 1,4'h9,0,8'h00,0,4'h0,0,2'd0,0}, // R2
        '{1,1,0,32'h5,        1,0,4'h0,4'h0, 0,4'h0,0,8'h00,0,4'h0,1,2'd0,0}, // R3
        '{0,1,0,32'h5,        1,0,4'h0,4'h0, 0,4'h0,0,8'h00,0,4'h0,1,2'd0,0}, // R3
        '{1,0,1,32'h5,        0,1,4'h2,4'h0, 0,4'h0,0,8'h00,0,4'h0,1,2'd1,0}, // R4
        '{1,0,0,32'h5,        1,0,4'h0,4'h0, 1,4'h9,0,8'h00,0,4'h0,0,2'd0,0}, // R4
        '{1,0,0,32'h5,        0,1,4'h5,4'h0, 0,4'h0,1,8'h50,0,4'h0,0,2'd0,0}, // R6
        '{1,0,0,32'hFFFF_FFF5,0,1,4'h4,4'h0, 0,4'h0,1,8'h40,0,4'h0,0,2'd0,1}, // R6
        '{1,0,0,32'h10,       0,1,4'h3,4'h0, 0,4'h0,1,8'h30,0,4'h0,0,2'd0,0}, // R6
        '{0,0,0,32'h5,        0,1,4'h7,4'h0, 0,4'h0,0,8'h00,1,4'h7,0,2'd0,0}, // R7
        '{0,0,0,32'h5,        1,0,4'h0,4'hA, 1,4'hA,0,8'h00,0,4'h0,0,2'd0,0}, // R7
        '{0,0,0,32'h5,        1,1,4'h6,4'hA, 1,4'h6,0,8'h00,1,4'h6,0,2'd0,0}, // R8
        '{1,0,0,32'h0,        1,1,4'hC,4'h0, 1,4'hC,1,8'hC0,0,4'h0,0,2'd0,0}, // R8
        '{1,1,0,32'h8,        1,1,4'h1,4'h0, 0,4'h0,1,8'h10,0,4'h0,0,2'd0,1}, // R8
        '{1,1,1,32'h5,        1,1,4'h5,4'h0, 0,4'h0,0,8'h00,0,4'h0,1,2'd1,0}, // R8
        '{1,0,0,32'h5,        1,0,4'h0,4'h0, 1,4'h1,0,8'h00,0,4'h0,0,2'd0,0}, // R4
        '{1,1,0,32'h0,        1,1,4'h9,4'h0, 0,4'h0,1,8'h90,0,4'h0,1,2'd0,0}  // R8
    };
    string vtag [NV] = '{"R5","R2","R3","R3","R4","R4","R6","R6","R6",
                         "R7","R7","R8","R8","R8","R8","R4","R8"};

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        rd_req_i = 1'b0; wr_req_i = 1'b0; wr_data_i = '0;
    endtask

    function automatic logic [24:0] observe1();
        return {rd_valid_o, rd_data_o & {4{rd_valid_o}},
                page_we_o, page_wdata_o & {8{page_we_o}},
                native_we_o, native_wdata_o & {4{native_we_o}},
                exit_o, exit_cause_o & {2{exit_o}}, 3'b000};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [24:0] got, want;
        rst = 1'b1;
        use_shadow_i = 1'b0; store_exit_en_i = 1'b0; load_exit_en_i = 1'b0;
        threshold_i = '0; native_rdata_i = '0;
        idle();
        repeat (3) @(negedge clk);
        // R1: reset state on all strobes
        check("R1", "reset strobes",
              {28'd0, rd_valid_o, page_we_o, native_we_o, exit_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        // R1: shadow reads back as 0 after reset
        use_shadow_i = 1'b1; rd_req_i = 1'b1;
        @(negedge clk);
        idle();
        check("R1", "shadow after reset", {27'd0, rd_valid_o, rd_data_o}, {27'd0, 1'b1, 4'h0});
        @(negedge clk);

        // Vector table: each entry is one request followed by one idle cycle
        for (int i = 0; i < NV; i++) begin
            use_shadow_i = VEC[i].use_s; store_exit_en_i = VEC[i].st;
            load_exit_en_i = VEC[i].ld; threshold_i = VEC[i].thr;
            rd_req_i = VEC[i].rd; wr_req_i = VEC[i].wr;
            wr_data_i = VEC[i].wd; native_rdata_i = VEC[i].nat;
            @(negedge clk);
            got = observe1();
            idle();
            @(negedge clk);
            got[2:0] = {exit_o, exit_cause_o & {2{exit_o}}};
            want = {VEC[i].rv, VEC[i].rdat, VEC[i].pwe, VEC[i].pdat,
                    VEC[i].nwe, VEC[i].ndat, VEC[i].ex, VEC[i].cs,
                    VEC[i].ex2, (VEC[i].ex2 ? 2'd2 : 2'd0)};
            check(vtag[i], $sformatf("vector %0d", i), {7'd0, got}, {7'd0, want});
        end

        // R5: page address of a shadow write
        use_shadow_i = 1'b1; store_exit_en_i = 1'b0; load_exit_en_i = 1'b0;
        threshold_i = 32'h0; wr_req_i = 1'b1; wr_data_i = 4'hB;
        @(negedge clk);
        idle();
        check("R5", "page address", {20'd0, page_addr_o}, 32'h080);
        @(negedge clk);

        // R9: request right after a below-threshold write is ignored
        threshold_i = 32'h8; wr_req_i = 1'b1; wr_data_i = 4'h2;
        @(negedge clk);
        check("R6", "below write page data", {24'd0, page_wdata_o}, 32'h20);
        wr_req_i = 1'b1; wr_data_i = 4'hF; rd_req_i = 1'b1;
        @(negedge clk);
        idle();
        check("R9", "exit while busy", {29'd0, exit_o, exit_cause_o}, {29'd0, 1'b1, 2'd2});
        check("R9", "ignored strobes", {29'd0, page_we_o, rd_valid_o, native_we_o}, 32'd0);
        @(negedge clk);
        check("R9", "no late effect", {29'd0, page_we_o, rd_valid_o, exit_o}, 32'd0);
        rd_req_i = 1'b1;
        @(negedge clk);
        idle();
        check("R9", "shadow kept", {27'd0, rd_valid_o, rd_data_o}, {27'd0, 1'b1, 4'h2});
        @(negedge clk);

        // R6: exit pulse lasts a single cycle
        check("R6", "exit pulse ended", {31'd0, exit_o}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule